// File: doc/BRIEF.md
# Complementary Gate Driver with Dead-Band Soft-Start

This block turns one raw square-wave phase of a resonant converter into a pair of complementary gate signals. The high-side output follows the raw phase, but its rising edge is held back by a programmable delay. The low-side output follows the inverted phase, and its rising edge is held back by a second delay that is set independently. Because each pulse is shortened by its delay, the same two delays set both the dead time and the duty of each output.

A soft-start ramp runs on top of this. A start pulse arms the ramp. At the next counter-zero strobe, both delays load with about 95% of the half-period, so each output begins with a pulse only a few percent of the cycle wide. At every later strobe, each delay drops by a fixed step until it settles at its own normal dead-band value. A done flag then rises. Over the ramp, each output's duty climbs gradually toward 50%. The delays change only at the strobe, so a pulse that is already in progress is never reshaped.

Top module: `deadband_softstart`

## Requirements
- R1: While the active delays are rise delay Dr and fall delay Df, each raw cycle of half-width H (raw high for H clocks, then low for H clocks) gives `gate_hi` high for exactly max(0, H−Dr) clocks at the end of the raw high half. It gives `gate_lo` high for exactly max(0, H−Df) clocks at the end of the raw low half.
- R2: After reset, and until the first delay load, both gate outputs and `ramp_done` are low, whatever the raw input does. A delay equal to or larger than H suppresses that output's pulse completely.
- R3: At the first `ctr_zero` strobe after a `start` pulse, the rise delay loads max(floor(19·H/20), `norm_rise`) and the fall delay loads max(floor(19·H/20), `norm_fall`). At the same strobe, `ramp_done` clears.
- R4: The active delays change only on a clock where `ctr_zero` is high. A `start` pulse in the middle of a cycle leaves that cycle's pulses unchanged.
- R5: At each later strobe during a ramp, each delay decreases by `step`, saturating at its own normal value. The rise and fall delays saturate independently.
- R6: `ramp_done` goes high at the strobe where both delays reach their normal values. It then stays high, with the delays unchanged, until a new start.
- R7: `gate_hi` and `gate_lo` are never high in the same clock.
- R8: Across a ramp, the high time of each output per cycle never decreases from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Raw 50% phase |
| half_per | input | CW | Half-period H of the raw phase, in clocks |
| norm_rise | input | CW | Normal rising-edge delay for `gate_hi` |
| norm_fall | input | CW | Normal rising-edge delay for `gate_lo` |
| step | input | CW | Amount subtracted from each delay per strobe |
| start | input | 1 | One-clock pulse that arms a soft-start ramp |
| ctr_zero | input | 1 | Strobe at time-base zero, coincident with the raw rising edge |
| gate_hi | output | 1 | High-side gate, rising-edge delayed |
| gate_lo | output | 1 | Low-side gate, inverted and delayed |
| ramp_done | output | 1 | Ramp has settled at the normal delays |

## Verification
Some properties are checked by assertions on every clock:
- Between strobes, the delays hold their values.
- An arming strobe starts the ramp with `ramp_done` low.
- A rising `ramp_done` lands exactly on the normal values.
- The two gates never overlap.
- A gate never rises on the first clock of its raw half while its delay is nonzero.

The exact pulse width in every cycle, the saturation points for several step sizes and normal values, the clamping of the start value, and the monotonic rise in duty are shown only by the bench's sweeps. The bench predicts each of these arithmetically.

// File: rtl/deadband_softstart.sv
module deadband_softstart #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_in,
  input  logic [CW-1:0] half_per,
  input  logic [CW-1:0] norm_rise,
  input  logic [CW-1:0] norm_fall,
  input  logic [CW-1:0] step,
  input  logic          start,
  input  logic          ctr_zero,
  output logic          gate_hi,
  output logic          gate_lo,
  output logic          ramp_done
);
  localparam int PW = CW + 5;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] red_q, fed_q, run_hi, run_lo;
  logic          pend_q, ramp_q, done_q;
  logic [PW-1:0] prod;
  logic [CW-1:0] p95, red_ld, fed_ld, red_nx, fed_nx;

  function automatic logic [CW-1:0] sat_step(input logic [CW-1:0] cur,
                                             input logic [CW-1:0] nrm,
                                             input logic [CW-1:0] stp);
    if (cur > nrm && (cur - nrm) > stp) return cur - stp;
    return nrm;
  endfunction

  assign prod   = PW'(half_per) * PW'(19);
  assign p95    = CW'(prod / PW'(20));
  assign red_ld = (p95 > norm_rise) ? p95 : norm_rise;
  assign fed_ld = (p95 > norm_fall) ? p95 : norm_fall;
  assign red_nx = sat_step(red_q, norm_rise, step);
  assign fed_nx = sat_step(fed_q, norm_fall, step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      red_q  <= CMAX;
      fed_q  <= CMAX;
      pend_q <= 1'b0;
      ramp_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (start) pend_q <= 1'b1;
      else if (ctr_zero) pend_q <= 1'b0;
      if (ctr_zero) begin
        if (pend_q) begin
          red_q  <= red_ld;
          fed_q  <= fed_ld;
          ramp_q <= 1'b1;
          done_q <= 1'b0;
        end else if (ramp_q) begin
          red_q <= red_nx;
          fed_q <= fed_nx;
          if (red_nx == norm_rise && fed_nx == norm_fall) begin
            ramp_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_hi <= '0;
      run_lo <= '0;
    end else begin
      run_hi <= !pwm_in ? '0 : (run_hi == CMAX ? run_hi : run_hi + 1'b1);
      run_lo <=  pwm_in ? '0 : (run_lo == CMAX ? run_lo : run_lo + 1'b1);
    end
  end

  wire live = ramp_q | done_q;
  assign gate_hi   = live &  pwm_in & (run_hi >= red_q);
  assign gate_lo   = live & ~pwm_in & (run_lo >= fed_q);
  assign ramp_done = done_q;

  p_delay_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctr_zero |=> ($stable(red_q) && $stable(fed_q)));

  p_arm_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ctr_zero) |=> (ramp_q && !done_q));

  p_done_norm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (red_q == $past(norm_rise) && fed_q == $past(norm_fall)));

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  p_rise_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_in && !$past(pwm_in) && red_q != '0) |-> !gate_hi);
endmodule

// File: tb/deadband_softstart_tb_top.sv
`timescale 1ns/1ps
module deadband_softstart_tb_top;
  localparam int CW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm_in = 1'b0, start = 1'b0, ctr_zero = 1'b0;
  logic [CW-1:0] half_per = '0, norm_rise = '0, norm_fall = '0, step = '0;
  logic gate_hi, gate_lo, ramp_done;
  int checks = 0, failures = 0;
  int m_dr = 1023, m_df = 1023, m_pend = 0, m_ramp = 0, m_done = 0;
  int last_hi = 0, last_lo = 0;

  always #2.5 clk = ~clk;

  deadband_softstart #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .half_per(half_per),
    .norm_rise(norm_rise), .norm_fall(norm_fall), .step(step),
    .start(start), .ctr_zero(ctr_zero),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .ramp_done(ramp_done));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int cur, input int nrm, input int stp);
    if (cur > nrm && cur - nrm > stp) return cur - stp;
    return nrm;
  endfunction

  task automatic run_cycle(input int start_at, output int nhi, output int nlo);
    int h = int'(half_per);
    int p95 = (h * 19) / 20;
    int ov = 0;
    nhi = 0; nlo = 0;
    if (m_pend != 0) begin
      m_dr = (p95 > int'(norm_rise)) ? p95 : int'(norm_rise);
      m_df = (p95 > int'(norm_fall)) ? p95 : int'(norm_fall);
      m_pend = 0; m_ramp = 1; m_done = 0;
    end else if (m_ramp != 0) begin
      m_dr = sat(m_dr, int'(norm_rise), int'(step));
      m_df = sat(m_df, int'(norm_fall), int'(step));
      if (m_dr == int'(norm_rise) && m_df == int'(norm_fall)) begin
        m_ramp = 0; m_done = 1;
      end
    end
    for (int i = 0; i < 2 * h; i++) begin
      @(negedge clk);
      pwm_in   = (i < h);
      ctr_zero = (i == 0);
      start    = (i == start_at);
      #1;
      if (gate_hi) nhi++;
      if (gate_lo) nlo++;
      if (gate_hi && gate_lo) ov++;
    end
    if (start_at >= 0) m_pend = 1;
    check("R7 overlap clocks", ov, 0);
    check("R1 hi width", nhi, (h > m_dr) ? h - m_dr : 0);
    check("R1 lo width", nlo, (h > m_df) ? h - m_df : 0);
    check("R6 done flag", int'(ramp_done), m_done);
  endtask

  task automatic ramp(input int h, input int nr, input int nf, input int st);
    int nhi, nlo, guard;
    half_per = CW'(h); norm_rise = CW'(nr); norm_fall = CW'(nf); step = CW'(st);
    run_cycle(h / 2, nhi, nlo);
    check("R4 no change before strobe", int'(ramp_done), m_done);
    run_cycle(-1, nhi, nlo);
    check("R3 load clears done", int'(ramp_done), 0);
    check("R3 start hi width", nhi, (h > m_dr) ? h - m_dr : 0);
    last_hi = nhi; last_lo = nlo;
    guard = 0;
    while (m_ramp != 0 && guard < 300) begin
      run_cycle(-1, nhi, nlo);
      checks++;
      if (nhi < last_hi || nlo < last_lo) begin
        failures++;
        $display("FAIL R8 duty fell actual=%0d/%0d expected>=%0d/%0d",
                 nhi, nlo, last_hi, last_lo);
      end
      last_hi = nhi; last_lo = nlo;
      guard++;
    end
    check("R5 settled rise width", last_hi, (h > nr) ? h - nr : 0);
    check("R5 settled fall width", last_lo, (h > nf) ? h - nf : 0);
    run_cycle(-1, nhi, nlo);
    check("R6 done holds hi", nhi, last_hi);
    check("R6 done holds lo", nlo, last_lo);
  endtask

  initial begin
    #(5.0 * 190000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int nhi, nlo;
    int hs[2]    = '{40, 24};
    int steps[4] = '{1, 3, 7, 50};
    int nrs[4]   = '{4, 10, 2, 39};
    int nfs[4]   = '{6, 3, 2, 5};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R2 reset gate_hi", int'(gate_hi), 0);
    check("R2 reset gate_lo", int'(gate_lo), 0);
    check("R2 reset done", int'(ramp_done), 0);
    half_per = CW'(40);
    run_cycle(-1, nhi, nlo);
    check("R2 idle hi suppressed", nhi, 0);
    check("R2 idle lo suppressed", nlo, 0);
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          ramp(hs[a], nrs[c], nfs[c], steps[b]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule